// File: doc/BRIEF.md
# Multi-Mode Block Deinterleaver Address Generator

This block produces the read-address sequence for a two-step block deinterleaver of the kind found in an OFDM receiver. The symbol buffer is organised as 16 rows and a number of columns that follows from the interleaving depth, which is the number of coded bits per symbol. The first step of the permutation walks the buffer row by row. The second step rotates columns inside small groups, and the group size depends on how many coded bits each subcarrier carries. The generator covers the 2-, 4- and 6-bit subcarrier modes and accepts the depth at run time.

A single shared front end takes the depth and derives two values from it: the column count (depth shifted right by four) and the last column index (that count minus one). All three modes then run on the same counters. The column rotation comes from an index-modulo-group counter, a row-modulo-group counter and a group-base accumulator. No multiplier, divider or lookup table is involved. A start pulse latches the mode and the depth. The block then emits one address per accepted cycle, along with valid and last-of-block flags. The downstream consumer can hold it with a ready signal.

Top module: `deintlv_addr_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `cfg_err_o` are all 0.
- R2: A start pulse while idle with an acceptable configuration latches `mode_i` and `depth_i`. From the next cycle `valid_o` is 1 and the first address is 0. Each cycle with `valid_o` and `ready_i` both high advances the sequence by one address. The order is row-major: the column index i is the inner loop and the row index j (0 to 15) is the outer loop.
- R3: With `mode_i` = 2'b00 (2 bits per subcarrier, group size 1), the address is j + 16·i. Rows 0 and 1 begin 0,16,32,48,64 and 1,17,33,49,65.
- R4: With `mode_i` = 2'b01 (4 bits per subcarrier, group size 2), odd rows swap each pair of columns. Row 1 begins 17,1,49,33,81 and row 2 begins 2,18,34,50,66.
- R5: With `mode_i` = 2'b10 (6 bits per subcarrier, group size 3), each group of three columns is rotated by j mod 3. Row 1 begins 17,33,1,65,81, row 2 begins 34,2,18,82,50 and row 4 begins 20,36,4,68,84.
- R6: For any depth that is a nonzero multiple of 16·s, the block has depth/16 columns. Every address equals j + 16·(s·⌊i/s⌋ + ((i mod s)+(j mod s)) mod s) and lies below the depth.
- R7: `last_o` is 1 exactly while the address for j = 15 and i = last column is presented. After that address is accepted, `valid_o` drops to 0 and stays 0 until the next start.
- R8: While `valid_o` is 1 and `ready_i` is 0, `addr_o`, `valid_o` and `last_o` hold their values into the next cycle.
- R9: A start while idle is refused if the mode code is 2'b11, the depth is 0, or the depth is not a multiple of 16·s. A refused start sets `cfg_err_o` to 1 in the next cycle and no block begins. The next accepted start clears `cfg_err_o`.
- R10: A start pulse while a block is in progress is ignored. The running sequence continues unchanged and `cfg_err_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a block with the presented mode and depth |
| mode_i | input | 2 | Bits per subcarrier: 00 = 2, 01 = 4, 10 = 6, 11 = reserved |
| depth_i | input | DEPTH_W | Interleaving depth in coded bits |
| ready_i | input | 1 | Downstream accepts the presented address |
| addr_o | output | DEPTH_W | Deinterleaver read address |
| valid_o | output | 1 | Address is valid |
| last_o | output | 1 | Address is the final one of the block |
| cfg_err_o | output | 1 | Most recent start while idle was refused |

## Verification
The bench builds the block with the default `DEPTH_W` of 12. This allows depths up to 4080, or 255 columns, so one run can drive the column counter and the group-base accumulator close to the top of their range. The same width also reaches the standard depths 96, 192 and 288 and non-standard depths such as 112, 480 and 64. Each of these is compared address by address against the closed-form rotation formula, both with and without random back-pressure. Refused configurations and starts issued in the middle of a block are applied at the ports.

// File: rtl/dia_pkg.sv
package dia_pkg;

  localparam int ROWS  = 16;
  localparam int ROW_W = 4;

  typedef enum logic [1:0] {
    MODE_B2  = 2'b00,
    MODE_B4  = 2'b01,
    MODE_B6  = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  // rotation group size for a mode; 0 marks the reserved code
  function automatic logic [1:0] grp_size(input mode_e m);
    case (m)
      MODE_B2: grp_size = 2'd1;
      MODE_B4: grp_size = 2'd2;
      MODE_B6: grp_size = 2'd3;
      default: grp_size = 2'd0;
    endcase
  endfunction

  // (a + b) mod g for a, b below g, using a single compare-and-subtract
  function automatic logic [2:0] rot_sum(input logic [1:0] a,
                                         input logic [1:0] b,
                                         input logic [1:0] g);
    logic [2:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    if (sum >= {1'b0, g}) rot_sum = sum - {1'b0, g};
    else                  rot_sum = sum;
  endfunction

  // modulo counter step within a group
  function automatic logic [1:0] mod_step(input logic [1:0] cur,
                                          input logic [1:0] g);
    if (cur == 2'(g - 2'd1)) mod_step = 2'd0;
    else                     mod_step = cur + 2'd1;
  endfunction

endpackage

// File: rtl/dia_front.sv
module dia_front
  import dia_pkg::*;
#(
  parameter int DEPTH_W = 12,
  localparam int COL_W  = DEPTH_W - ROW_W
) (
  input  logic [1:0]         mode_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [COL_W-1:0]   last_col_o,
  output logic [1:0]         gsize_o,
  output logic               cfg_ok_o
);

  logic [COL_W-1:0] ncols;
  logic             grp_ok;

  // the shared divide-by-16 and minus-one stage
  assign ncols      = depth_i[DEPTH_W-1:ROW_W];
  assign last_col_o = ncols - COL_W'(1);
  assign gsize_o    = grp_size(mode_e'(mode_i));

  always_comb begin
    case (gsize_o)
      2'd1:    grp_ok = 1'b1;
      2'd2:    grp_ok = ~ncols[0];
      2'd3:    grp_ok = ((ncols % COL_W'(3)) == '0);
      default: grp_ok = 1'b0;
    endcase
  end

  assign cfg_ok_o = (depth_i[ROW_W-1:0] == '0) && (ncols != '0) && grp_ok;

  // R9: an accepted configuration never carries the reserved mode code
  always_comb begin
    a_cfg_mode_r9: assert (!(cfg_ok_o && mode_i == MODE_RSV));
  end

endmodule

// File: rtl/dia_col_ctr.sv
module dia_col_ctr
  import dia_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [COL_W-1:0] last_col_i,
  input  logic [1:0]       gsize_i,
  output logic [COL_W-1:0] col_idx_o,
  output logic [1:0]       col_mod_o,
  output logic [COL_W-1:0] grp_base_o,
  output logic             at_last_o
);

  assign at_last_o = (col_idx_o == last_col_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_idx_o  <= '0;
      col_mod_o  <= '0;
      grp_base_o <= '0;
    end else if (clr_i) begin
      col_idx_o  <= '0;
      col_mod_o  <= '0;
      grp_base_o <= '0;
    end else if (step_i) begin
      if (at_last_o) begin
        col_idx_o  <= '0;
        col_mod_o  <= '0;
        grp_base_o <= '0;
      end else begin
        col_idx_o <= col_idx_o + COL_W'(1);
        col_mod_o <= mod_step(col_mod_o, gsize_i);
        if (col_mod_o == 2'(gsize_i - 2'd1))
          grp_base_o <= grp_base_o + COL_W'(gsize_i);
      end
    end
  end

  // R6: the position inside a group stays below the group size
  p_col_mod_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gsize_i != 2'd0) |-> (col_mod_o < gsize_i));

  // R6: group base plus offset always reconstructs the column index
  p_col_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_base_o + COL_W'(col_mod_o)) == col_idx_o);

endmodule

// File: rtl/dia_row_ctr.sv
module dia_row_ctr
  import dia_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [1:0]       gsize_i,
  output logic [ROW_W-1:0] row_idx_o,
  output logic [1:0]       row_mod_o,
  output logic             at_end_o
);

  assign at_end_o = (row_idx_o == ROW_W'(ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_idx_o <= '0;
      row_mod_o <= '0;
    end else if (clr_i) begin
      row_idx_o <= '0;
      row_mod_o <= '0;
    end else if (step_i) begin
      row_idx_o <= row_idx_o + ROW_W'(1);
      row_mod_o <= at_end_o ? 2'd0 : mod_step(row_mod_o, gsize_i);
    end
  end

  // R5: the row rotation amount stays below the group size
  p_row_mod_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gsize_i != 2'd0) |-> (row_mod_o < gsize_i));

endmodule

// File: rtl/deintlv_addr_gen.sv
module deintlv_addr_gen
  import dia_pkg::*;
#(
  parameter int DEPTH_W = 12,
  localparam int COL_W  = DEPTH_W - ROW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               ready_i,
  output logic [DEPTH_W-1:0] addr_o,
  output logic               valid_o,
  output logic               last_o,
  output logic               cfg_err_o
);

  // front end outputs
  logic [COL_W-1:0]   last_col_w;
  logic [1:0]         gsize_w;
  logic               cfg_ok_w;

  // latched block configuration
  logic               active_q;
  logic               err_q;
  logic [COL_W-1:0]   last_col_q;
  logic [1:0]         gsize_q;
  logic [DEPTH_W-1:0] depth_q;

  // counter state
  logic [COL_W-1:0]   col_idx, grp_base;
  logic [1:0]         col_mod, row_mod;
  logic [ROW_W-1:0]   row_idx;
  logic               col_at_last, row_at_end;

  // named internal events
  logic               start_ok, start_bad, fire, row_step, block_done;
  logic [2:0]         rot;
  logic [COL_W-1:0]   col_sel;

  dia_front #(.DEPTH_W(DEPTH_W)) u_front (
    .mode_i    (mode_i),
    .depth_i   (depth_i),
    .last_col_o(last_col_w),
    .gsize_o   (gsize_w),
    .cfg_ok_o  (cfg_ok_w)
  );

  assign start_ok   = start_i & ~active_q & cfg_ok_w;
  assign start_bad  = start_i & ~active_q & ~cfg_ok_w;
  assign fire       = active_q & ready_i;
  assign row_step   = fire & col_at_last;
  assign block_done = row_step & row_at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      err_q      <= 1'b0;
      last_col_q <= '0;
      gsize_q    <= 2'd1;
      depth_q    <= '0;
    end else if (start_ok) begin
      active_q   <= 1'b1;
      err_q      <= 1'b0;
      last_col_q <= last_col_w;
      gsize_q    <= gsize_w;
      depth_q    <= depth_i;
    end else if (start_bad) begin
      err_q      <= 1'b1;
    end else if (block_done) begin
      active_q   <= 1'b0;
    end
  end

  dia_col_ctr #(.COL_W(COL_W)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (start_ok),
    .step_i    (fire),
    .last_col_i(last_col_q),
    .gsize_i   (gsize_q),
    .col_idx_o (col_idx),
    .col_mod_o (col_mod),
    .grp_base_o(grp_base),
    .at_last_o (col_at_last)
  );

  dia_row_ctr u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (start_ok),
    .step_i   (row_step),
    .gsize_i  (gsize_q),
    .row_idx_o(row_idx),
    .row_mod_o(row_mod),
    .at_end_o (row_at_end)
  );

  // intra-group rotation and address assembly: column above, row below
  assign rot       = rot_sum(col_mod, row_mod, gsize_q);
  assign col_sel   = grp_base + COL_W'(rot);
  assign addr_o    = {col_sel, row_idx};
  assign valid_o   = active_q;
  assign last_o    = active_q & col_at_last & row_at_end;
  assign cfg_err_o = err_q;

  p_first_addr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> (addr_o == '0));

  p_addr_in_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (addr_o < depth_q));

  p_last_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  p_idle_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && last_o) |=> !valid_o);

  p_hold_when_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(last_o)));

  p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !valid_o);

  p_no_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> valid_o);

  p_err_kept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> $stable(cfg_err_o));

endmodule

// File: tb/sim_deintlv_addr_gen.sv
`timescale 1ns/1ps
module sim_deintlv_addr_gen;

  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [DW-1:0] depth_i = '0;
  logic          ready_i = 1'b0;
  logic [DW-1:0] addr_o;
  logic          valid_o, last_o, cfg_err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  deintlv_addr_gen #(.DEPTH_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .depth_i(depth_i), .ready_i(ready_i), .addr_o(addr_o),
    .valid_o(valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // closed-form reference address
  function automatic int ref_addr(input int s, input int j, input int i);
    return j + 16 * (s * (i / s) + ((i % s) + (j % s)) % s);
  endfunction

  function automatic int gsz(input int mode);
    return (mode == 0) ? 1 : (mode == 1) ? 2 : 3;
  endfunction

  task automatic next_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_block(input int mode, input int depth, input string req,
                           input bit stall, input int poke_at);
    int s = gsz(mode);
    int ncols = depth / 16;
    int expq[$];
    int idx = 0;
    int guard = 0;
    int prev_addr = 0;
    bit prev_fire = 1'b1;
    for (int j = 0; j < 16; j++)
      for (int i = 0; i < ncols; i++)
        expq.push_back(ref_addr(s, j, i));
    @(negedge clk);
    mode_i  = 2'(mode);
    depth_i = DW'(depth);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(cfg_err_o == 1'b0, "R9 err cleared by accepted start", int'(cfg_err_o), 0);
    check(valid_o == 1'b1 && addr_o == '0, "R2 first address", int'(addr_o), 0);
    while (idx < depth && guard < 8 * depth + 50) begin
      check(valid_o == 1'b1, "R2 valid during block", int'(valid_o), 1);
      check(int'(addr_o) == expq[idx], req, int'(addr_o), expq[idx]);
      check(last_o == (idx == depth - 1), "R7 last flag", int'(last_o), int'(idx == depth - 1));
      if (!prev_fire)
        check(int'(addr_o) == prev_addr, "R8 hold while stalled", int'(addr_o), prev_addr);
      if (idx == poke_at) begin
        mode_i  = 2'b00;
        depth_i = DW'(16);
        start_i = 1'b1;
      end
      next_lfsr();
      ready_i   = stall ? (lfsr[0] | lfsr[1]) : 1'b1;
      prev_fire = ready_i;
      prev_addr = int'(addr_o);
      @(negedge clk);
      start_i = 1'b0;
      if (prev_fire) idx++;
      guard++;
    end
    if (idx < depth) check(1'b0, "R2 block did not complete", idx, depth);
    check(valid_o == 1'b0, "R7 idle after last", int'(valid_o), 0);
    check(cfg_err_o == 1'b0, "R10 err untouched by busy start", int'(cfg_err_o), 0);
    ready_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(valid_o == 1'b0 && last_o == 1'b0, "R7 stays idle", int'(valid_o), 0);
    end
  endtask

  task automatic bad_start(input int mode, input int depth);
    @(negedge clk);
    mode_i  = 2'(mode);
    depth_i = DW'(depth);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(cfg_err_o == 1'b1, "R9 refused start flags error", int'(cfg_err_o), 1);
    check(valid_o == 1'b0, "R9 refused start emits nothing", int'(valid_o), 0);
    repeat (2) begin
      @(negedge clk);
      check(valid_o == 1'b0 && cfg_err_o == 1'b1, "R9 refusal persists", int'(valid_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid after reset", int'(valid_o), 0);
    check(last_o == 1'b0, "R1 last after reset", int'(last_o), 0);
    check(cfg_err_o == 1'b0, "R1 err after reset", int'(cfg_err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_block(0, 96,   "R3 2-bit mode address", 1'b0, -1);
    run_block(0, 96,   "R3 2-bit mode under stall", 1'b1, -1);
    run_block(1, 192,  "R4 4-bit mode pair swap", 1'b1, 40);
    run_block(2, 288,  "R5 6-bit mode rotation", 1'b1, 100);
    run_block(2, 480,  "R6 non-standard depth 6-bit", 1'b1, -1);
    run_block(0, 112,  "R6 non-standard depth 2-bit", 1'b1, -1);
    run_block(1, 64,   "R6 small depth 4-bit", 1'b0, -1);
    bad_start(1, 200);
    bad_start(3, 96);
    bad_start(2, 112);
    bad_start(0, 0);
    run_block(2, 96,   "R5 6-bit after refusal", 1'b1, -1);
    run_block(0, 4080, "R6 largest depth", 1'b0, 1000);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule